// File: doc/BRIEF.md
# Queued Infrared Pulse-Train Sequencer

This block feeds a PWM channel from a short queue of 16-bit waveform entries. It is meant for infrared remote-control frames. Software, or any producer, pushes entries into an eight-deep queue. The sequencer takes one entry at a time and holds it while the PWM channel emits the number of pulses the entry asks for. The channel reports the end of each pulse on `pulse_end`. Each entry also chooses which of two timing sets (compare length and max length) the channel must use: the primary pair or the shadow pair. It also chooses whether the carrier is driven or the output is held idle for those pulses.

The next entry is taken only after the current entry's pulses are all used up. When the queue runs dry the sequencer goes idle and latches a done flag. The queue reports its occupancy, an empty bit and a full bit in one status word. A programmable refill level raises a maskable flag while occupancy is below it, so the producer knows to top the queue up. A flush input discards the queued entries and the entry in progress.

Top module: `ir_wave_sequencer`

## Requirements
- R1: A push while the queue holds fewer than 8 entries stores the entry. A push while 8 entries are held is dropped and leaves the occupancy at 8. When `flush` and a push arrive in the same cycle, the push is dropped.
- R2: `queue_status` reports occupancy in bits [3:0], empty (occupancy 0) in bit 4 and full (occupancy 8) in bit 5.
- R3: The bits of an entry are split as follows: [13:0] is the pulse count, bit 14 selects the shadow timing set when 1, and bit 15 enables the carrier when 1. While an entry is in progress:
  - `cmp_len` and `max_len` show the timing set that entry selects.
  - `carrier_on` equals its bit 15.
  - `pulses_left` shows its remaining pulse count.
- R4: A stored entry is taken from the queue one cycle after the sequencer is idle with a non-empty queue. After that, the next entry is taken only in the cycle its predecessor's remaining count reaches zero. Each `pulse_end` high cycle while busy consumes one pulse.
- R5: When an entry finishes and the queue is empty, `busy` drops on the next edge and `done_flag` is set. `done_flag` stays set until `done_clr` is pulsed (write-one-to-clear).
- R6: `flush` empties the queue and abandons the entry in progress within one edge, and it does not set `done_flag`.
- R7: `refill_flag` is set at every edge where occupancy is below `refill_level`. It is cleared by `refill_clr` only when that condition is false. `refill_irq` is `refill_flag` gated by `refill_mask`.
- R8: An entry with a pulse count of zero is retired one cycle after it is taken, without waiting for `pulse_end`.
- R9: After reset the queue is empty, the sequencer is idle, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Write one entry into the queue this cycle |
| push_entry | input | 16 | Entry: [15] carrier, [14] shadow select, [13:0] pulse count |
| flush | input | 1 | Empty the queue and abandon the current entry |
| pulse_end | input | 1 | PWM channel finished one pulse |
| prim_cmp_len | input | 16 | Primary compare length |
| prim_max_len | input | 16 | Primary max length |
| shad_cmp_len | input | 16 | Shadow compare length |
| shad_max_len | input | 16 | Shadow max length |
| refill_level | input | 4 | Occupancy threshold for the refill flag |
| refill_mask | input | 1 | Enables `refill_irq` |
| refill_clr | input | 1 | Write-one-to-clear strobe for `refill_flag` |
| done_clr | input | 1 | Write-one-to-clear strobe for `done_flag` |
| busy | output | 1 | An entry is in progress |
| carrier_on | output | 1 | Carrier requested for the current entry |
| pulses_left | output | 14 | Remaining pulses of the current entry |
| cmp_len | output | 16 | Compare length selected for the current entry |
| max_len | output | 16 | Max length selected for the current entry |
| queue_status | output | 6 | {full, empty, occupancy[3:0]} |
| refill_flag | output | 1 | Refill condition has been seen |
| refill_irq | output | 1 | Masked refill flag |
| done_flag | output | 1 | Queue drained and sequencer stopped |

## Verification
Errors in the ring pointers or the occupancy counter show up in `queue_status` on the edge after the push or pop that caused them. The bench steps occupancy through every value from 0 to 8 and past full. A wrong remaining-count or entry-select state changes `pulses_left`, `cmp_len` or `carrier_on` one cycle too early or too late at the entry boundary. It can also set `done_flag` while entries are still queued. The bench samples these outputs on every pulse around each boundary. The refill comparison is swept across all sixteen levels and across every occupancy value, so an off-by-one in the comparison shows up on the very next edge.

// File: rtl/irseq_pkg.sv
package irseq_pkg;

  localparam int ENTRY_W = 16;
  localparam int PCNT_W  = 14;
  localparam int SHADOW_BIT  = 14;
  localparam int CARRIER_BIT = 15;

  typedef struct packed {
    logic              carrier;
    logic              shadow;
    logic [PCNT_W-1:0] pulses;
  } irseq_entry_t;

  // The current entry is used up this cycle.
  function automatic logic entry_exhausted(input logic busy_i,
                                           input logic [PCNT_W-1:0] left_i,
                                           input logic pulse_i);
    return busy_i && ((left_i == '0) || (pulse_i && (left_i == PCNT_W'(1))));
  endfunction

  // Occupancy compared against the refill level.
  function automatic logic below_level(input logic [7:0] occ_i,
                                       input logic [7:0] lvl_i);
    return occ_i < lvl_i;
  endfunction

  // Ring pointer advance for any depth.
  function automatic int unsigned ring_next(input int unsigned ptr_i,
                                            input int unsigned depth_i);
    return (ptr_i == depth_i - 1) ? 0 : ptr_i + 1;
  endfunction

endpackage

// File: rtl/irseq_fifo.sv
module irseq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [OCC_W-1:0] occupancy,
  output logic             is_empty,
  output logic             is_full,
  output logic             wr_accept
);
  import irseq_pkg::*;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             rd_fire;

  assign is_empty  = (occupancy == '0);
  assign is_full   = (occupancy == OCC_W'(DEPTH));
  assign wr_accept = wr_en && !is_full && !clear;
  assign rd_fire   = rd_en && !is_empty && !clear;
  assign rd_data   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_accept) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
    end else if (clear) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
    end else begin
      if (wr_accept) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_fire)   rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({wr_accept, rd_fire})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

endmodule

// File: rtl/irseq_engine.sv
module irseq_engine
  import irseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               pulse_end,
  input  logic               queue_empty,
  input  irseq_entry_t       head,
  output logic               take,
  output logic               exhaust,
  output logic               finish_evt,
  output logic               busy,
  output logic               use_shadow,
  output logic               carrier,
  output logic [PCNT_W-1:0]  left
);

  assign exhaust    = entry_exhausted(busy, left, pulse_end);
  assign take       = !queue_empty && (!busy || exhaust) && !flush;
  assign finish_evt = exhaust && queue_empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      use_shadow <= 1'b0;
      carrier    <= 1'b0;
      left       <= '0;
    end else if (flush) begin
      busy       <= 1'b0;
      carrier    <= 1'b0;
      left       <= '0;
    end else if (take) begin
      busy       <= 1'b1;
      use_shadow <= head.shadow;
      carrier    <= head.carrier;
      left       <= head.pulses;
    end else if (exhaust) begin
      busy       <= 1'b0;
      carrier    <= 1'b0;
      left       <= '0;
    end else if (busy && pulse_end) begin
      left       <= left - 1'b1;
    end
  end

endmodule

// File: rtl/irseq_w1c_flag.sv
module irseq_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/ir_wave_sequencer.sv
module ir_wave_sequencer
  import irseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int LVL_W = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               flush,
  input  logic               pulse_end,
  input  logic [LEN_W-1:0]   prim_cmp_len,
  input  logic [LEN_W-1:0]   prim_max_len,
  input  logic [LEN_W-1:0]   shad_cmp_len,
  input  logic [LEN_W-1:0]   shad_max_len,
  input  logic [LVL_W-1:0]   refill_level,
  input  logic               refill_mask,
  input  logic               refill_clr,
  input  logic               done_clr,
  output logic               busy,
  output logic               carrier_on,
  output logic [PCNT_W-1:0]  pulses_left,
  output logic [LEN_W-1:0]   cmp_len,
  output logic [LEN_W-1:0]   max_len,
  output logic [OCC_W+1:0]   queue_status,
  output logic               refill_flag,
  output logic               refill_irq,
  output logic               done_flag
);

  logic [ENTRY_W-1:0] head_raw;
  logic [OCC_W-1:0]   occ;
  logic               q_empty, q_full, push_taken;
  logic               take_w, exhaust_w, finish_w;
  logic               shadow_sel, carrier_r;
  logic               below_w;

  irseq_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .wr_en     (push_valid),
    .wr_data   (push_entry),
    .rd_en     (take_w),
    .rd_data   (head_raw),
    .occupancy (occ),
    .is_empty  (q_empty),
    .is_full   (q_full),
    .wr_accept (push_taken)
  );

  irseq_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .pulse_end   (pulse_end),
    .queue_empty (q_empty),
    .head        (irseq_entry_t'(head_raw)),
    .take        (take_w),
    .exhaust     (exhaust_w),
    .finish_evt  (finish_w),
    .busy        (busy),
    .use_shadow  (shadow_sel),
    .carrier     (carrier_r),
    .left        (pulses_left)
  );

  assign below_w = below_level(8'(occ), 8'(refill_level));

  irseq_w1c_flag u_refill (
    .clk(clk), .rst_n(rst_n), .set_i(below_w), .clr_i(refill_clr), .flag_o(refill_flag)
  );

  irseq_w1c_flag u_done (
    .clk(clk), .rst_n(rst_n), .set_i(finish_w), .clr_i(done_clr), .flag_o(done_flag)
  );

  assign refill_irq   = refill_flag && refill_mask;
  assign carrier_on   = busy && carrier_r;
  assign cmp_len      = shadow_sel ? shad_cmp_len : prim_cmp_len;
  assign max_len      = shadow_sel ? shad_max_len : prim_max_len;
  assign queue_status = {q_full, q_empty, occ};

endmodule

// File: rtl/ir_wave_sequencer_chk.sv
module ir_wave_sequencer_chk #(
  parameter int DEPTH = 8,
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             flush,
  input logic             take_w,
  input logic             exhaust_w,
  input logic             finish_w,
  input logic             below_w,
  input logic             busy,
  input logic             q_full,
  input logic [OCC_W-1:0] occ,
  input logic             refill_flag,
  input logic             done_flag
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R1

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && push_valid && !take_w && !flush) |=> (occ == OCC_W'(DEPTH))); // R1

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exhaust_w && !flush) |=> (occ >= $past(occ))); // R4

  AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> (!busy && done_flag)); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0 && !busy)); // R6

  AST_REFILL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    below_w |=> refill_flag); // R7

endmodule

bind ir_wave_sequencer ir_wave_sequencer_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid  (push_valid),
  .flush       (flush),
  .take_w      (take_w),
  .exhaust_w   (exhaust_w),
  .finish_w    (finish_w),
  .below_w     (below_w),
  .busy        (busy),
  .q_full      (q_full),
  .occ         (occ),
  .refill_flag (refill_flag),
  .done_flag   (done_flag)
);

// File: tb/ir_wave_sequencer_bench.sv
module ir_wave_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [15:0] push_entry = '0;
  logic        flush = 1'b0;
  logic        pulse_end = 1'b0;
  logic [15:0] prim_cmp_len = 16'h0011;
  logic [15:0] prim_max_len = 16'h0022;
  logic [15:0] shad_cmp_len = 16'h0033;
  logic [15:0] shad_max_len = 16'h0044;
  logic [3:0]  refill_level = 4'd0;
  logic        refill_mask = 1'b0;
  logic        refill_clr = 1'b0;
  logic        done_clr = 1'b0;
  logic        busy, carrier_on, refill_flag, refill_irq, done_flag;
  logic [13:0] pulses_left;
  logic [15:0] cmp_len, max_len;
  logic [5:0]  queue_status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ir_wave_sequencer u_ir_wave_sequencer (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int status_of(input int occ);
    return ((occ == 8) ? 32 : 0) + ((occ == 0) ? 16 : 0) + occ;
  endfunction

  task automatic push(input logic [15:0] e);
    push_valid = 1'b1; push_entry = e;
    step();
    push_valid = 1'b0;
  endtask

  task automatic clear_refill();
    refill_clr = 1'b1; step(); refill_clr = 1'b0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9", "status", int'(queue_status), status_of(0));
    chk("R9", "busy", int'(busy), 0);
    chk("R9", "done", int'(done_flag), 0);
    chk("R9", "refill", int'(refill_flag), 0);

    // R1/R2 fill sweep behind a long entry (carrier, shadow, 100 pulses)
    push({1'b1, 1'b1, 14'd100});
    chk("R2", "occ after first push", int'(queue_status), status_of(1));
    step();
    chk("R4", "first entry taken", int'(busy), 1);
    chk("R3", "left", int'(pulses_left), 100);
    chk("R3", "shadow cmp", int'(cmp_len), 16'h0033);
    chk("R3", "shadow max", int'(max_len), 16'h0044);
    chk("R3", "carrier", int'(carrier_on), 1);
    for (int i = 1; i <= 8; i++) begin
      push(16'(i));
      chk("R2", $sformatf("status at %0d", i), int'(queue_status), status_of(i));
    end
    push(16'h0005);
    chk("R1", "push when full dropped", int'(queue_status), status_of(8));

    // R7 occupancy sweep with level 5 (queue currently full, entry held)
    refill_level = 4'd5;
    for (int k = 8; k >= 0; k--) begin
      if (k < 8) begin
        // drain one entry via flush-free path: not possible while held, so rebuild
        flush = 1'b1; step(); flush = 1'b0;
        push({2'b00, 14'd200}); step();
        for (int j = 0; j < k; j++) push(16'd1);
      end
      clear_refill();
      chk("R7", $sformatf("flag at occ %0d", k), int'(refill_flag), (k < 5) ? 1 : 0);
    end

    // R6 flush
    flush = 1'b1; step(); flush = 1'b0;
    chk("R6", "occ after flush", int'(queue_status), status_of(0));
    chk("R6", "busy after flush", int'(busy), 0);
    chk("R6", "no done on flush", int'(done_flag), 0);

    // R7 level sweep at occupancy 0, mask gating
    for (int lvl = 0; lvl < 16; lvl++) begin
      refill_level = 4'(lvl);
      refill_mask  = lvl[0];
      step();
      clear_refill();
      chk("R7", $sformatf("flag at level %0d", lvl), int'(refill_flag), (lvl > 0) ? 1 : 0);
      chk("R7", $sformatf("irq at level %0d", lvl), int'(refill_irq), (lvl > 0) ? lvl % 2 : 0);
    end
    refill_level = 4'd0; refill_mask = 1'b0;
    clear_refill();
    chk("R7", "clear when condition false", int'(refill_flag), 0);

    // R3/R4/R5/R8 entry sequence
    push({1'b1, 1'b0, 14'd3});
    push({1'b0, 1'b1, 14'd2});
    push({1'b1, 1'b1, 14'd0});
    chk("R4", "occ with A active", int'(queue_status), status_of(2));
    chk("R3", "A cmp primary", int'(cmp_len), 16'h0011);
    chk("R3", "A max primary", int'(max_len), 16'h0022);
    chk("R3", "A carrier", int'(carrier_on), 1);
    pulse_end = 1'b1;
    step(); step();
    chk("R4", "A left after 2 pulses", int'(pulses_left), 1);
    chk("R4", "B still queued", int'(queue_status), status_of(2));
    step();
    chk("R4", "B taken", int'(pulses_left), 2);
    chk("R3", "B shadow cmp", int'(cmp_len), 16'h0033);
    chk("R3", "B carrier idle", int'(carrier_on), 0);
    chk("R2", "occ with B", int'(queue_status), status_of(1));
    step(); step();
    pulse_end = 1'b0;
    chk("R8", "C taken", int'(busy), 1);
    chk("R8", "C left", int'(pulses_left), 0);
    chk("R5", "no done yet", int'(done_flag), 0);
    step();
    chk("R8", "C retired without pulse", int'(busy), 0);
    chk("R5", "done set", int'(done_flag), 1);
    pulse_end = 1'b1; step(); pulse_end = 1'b0; step();
    chk("R5", "done held", int'(done_flag), 1);
    done_clr = 1'b1; step(); done_clr = 1'b0;
    chk("R5", "done cleared", int'(done_flag), 0);

    // R1 flush with simultaneous push
    flush = 1'b1; push_valid = 1'b1; push_entry = 16'd7;
    step();
    flush = 1'b0; push_valid = 1'b0;
    step();
    chk("R1", "push during flush dropped", int'(queue_status), status_of(0));
    chk("R1", "idle after flush push", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule